// File: doc/BRIEF.md
# MLT-3 Receive Decoder and Five-Bit Deserializer

This block sits behind the receive window comparators of a 100 Mb/s copper link. Each cycle of the 125 MHz recovered clock it takes one sliced line level. It turns any nonzero level into a high NRZI sample and converts the NRZI waveform to NRZ. It then packs five consecutive bits into a code group for the coding layer above. Finished groups are held in a register and driven out against a 25 MHz receive clock, which is made by dividing the recovered clock by five. The output data changes only on the falling edge of that clock, so the coding layer can sample on the rising edge with half a period of margin on either side.

A loopback control replaces the line-derived NRZI with the local transmit serial stream. While loopback is on, signal-detect is forced high. With loopback off, signal-detect follows an external amplitude-qualified input.

Top module: `mlt3_rx_deser`

## Requirements
- R1: The line level code is read as signed two-bit: 2'b01 is above the positive threshold, 2'b11 and 2'b10 are below the negative threshold, and 2'b00 is the zero level. A nonzero level gives an NRZI sample of 1 and the zero level gives 0.
- R2: Each NRZ bit is 1 when the current NRZI sample differs from the previous one and 0 when it is the same. The previous sample is 0 after reset.
- R3: Groups are five consecutive bits, and the first group begins with the bit sampled on the first clock edge after reset is released. The first bit received in a group lands in rx_grp bit 0 and the fifth lands in bit 4.
- R4: A group appears on rx_grp at the first falling edge of rx_clk25 after its fifth bit is sampled. It stays there until the next falling edge, which is five fast cycles later.
- R5: rx_grp changes only at the instant rx_clk25 falls.
- R6: rx_clk25 has a period of five fast cycles and is high for two and a half of them. It rises at the fast edge that completes a group.
- R7: While lb_en is high, the NRZI stream comes from tx_nrzi and line_sym has no effect on rx_grp.
- R8: sig_det is 1 while lb_en is high and equals sig_amp_ok while lb_en is low.
- R9: While rst_n is low, rx_grp is 0 and rx_clk25 is high. Reset also restarts the group phase, so an asynchronous reset in the middle of a stream realigns the groups to the release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_sym | input | 2 | Sliced line level, signed code |
| lb_en | input | 1 | Loopback select |
| tx_nrzi | input | 1 | Transmit serial NRZI stream used in loopback |
| sig_amp_ok | input | 1 | External amplitude-qualified signal-detect |
| rx_clk25 | output | 1 | Divide-by-five receive clock |
| rx_grp | output | GW | Received code group |
| sig_det | output | 1 | Signal-detect output |

## Verification
A wrong group phase, a slipped shift or a stale previous-NRZI bit shows on rx_grp as a rotated or bit-inverted group. This appears within two group times of the fault, at the next falling edge of rx_clk25. A fault in the divider shows at once, as a changed high time or as rx_grp moving at some instant other than the falling edge. A bad loopback mux shows within two groups, because the bench drives line_sym with the complement of the true level while loopback is on.

// File: rtl/mlt3_rx_deser.sv
module mlt3_rx_deser #(
  parameter int GW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    line_sym,
  input  logic          lb_en,
  input  logic          tx_nrzi,
  input  logic          sig_amp_ok,
  output logic          rx_clk25,
  output logic [GW-1:0] rx_grp,
  output logic          sig_det
);
  localparam int PW = $clog2(GW);
  localparam int HI = GW / 2;
  localparam logic [PW-1:0] LAST = PW'(GW - 1);
  localparam logic [PW-1:0] HI_END = PW'(HI - 1);

  logic above_pos, below_neg, line_nrzi, nrzi_in, nrzi_q, nrz;
  logic [PW-1:0] ph;
  logic [GW-2:0] sh;
  logic [GW-1:0] hold;
  logic hi_p, hi_n;

  assign above_pos = ~line_sym[1] & line_sym[0];
  assign below_neg = line_sym[1];
  assign line_nrzi = above_pos | below_neg;
  assign nrzi_in   = lb_en ? tx_nrzi : line_nrzi;
  assign nrz       = nrzi_in ^ nrzi_q;
  assign sig_det   = lb_en | sig_amp_ok;
  assign rx_clk25  = hi_p | hi_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrzi_q <= 1'b0;
      ph     <= '0;
      sh     <= '0;
      hold   <= '0;
      hi_p   <= 1'b1;
    end else begin
      nrzi_q <= nrzi_in;
      sh     <= {nrz, sh[GW-2:1]};
      if (ph == LAST) begin
        ph   <= '0;
        hold <= {nrz, sh};
      end else begin
        ph <= ph + 1'b1;
      end
      hi_p <= (ph == LAST) || (ph < HI_END);
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_n   <= 1'b1;
      rx_grp <= '0;
    end else begin
      hi_n <= hi_p;
      if (hi_n && !hi_p) rx_grp <= hold;
    end
  end

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == LAST) |=> (ph == '0)); // R6
  AST_HOLD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != LAST) |=> $stable(hold)); // R4
  AST_GRP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PW'(HI)) |-> $stable(rx_grp)); // R5
  AST_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == '0 && $past(ph) == LAST) |-> rx_clk25); // R6
  AST_LOOP_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    lb_en |-> sig_det); // R8
endmodule

// File: tb/sim_mlt3_rx_deser.sv
`timescale 1ns/1ps
module sim_mlt3_rx_deser;
  localparam int GW = 5;
  // {alt_neg, amp, lb, word[4:0]}
  localparam logic [7:0] VEC [10] = '{
    8'b0_1_0_10110, 8'b0_1_0_11111, 8'b0_0_0_00000, 8'b1_1_0_10101,
    8'b0_0_1_01001, 8'b0_1_1_11110, 8'b1_1_0_00111, 8'b0_1_0_10001,
    8'b0_1_0_01101, 8'b1_0_0_11000
  };

  logic clk = 0, rst_n = 0, lb_en = 0, tx_nrzi = 0, sig_amp_ok = 1;
  logic [1:0] line_sym = 2'b00;
  logic rx_clk25, sig_det;
  logic [GW-1:0] rx_grp;
  int checks = 0, fails = 0, hi_cnt = 0, smp_cnt = 0;
  logic s = 0, neg = 1, prev_clk;
  logic [GW-1:0] prev_grp;
  logic done = 0;

  always #2 clk = ~clk;

  mlt3_rx_deser #(.GW(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .line_sym(line_sym), .lb_en(lb_en),
    .tx_nrzi(tx_nrzi), .sig_amp_ok(sig_amp_ok), .rx_clk25(rx_clk25),
    .rx_grp(rx_grp), .sig_det(sig_det));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b, input logic lb, input logic amp, input logic alt);
    logic [1:0] code;
    if (b) begin
      s = ~s;
      if (s) neg = ~neg;
    end
    code = s ? (neg ? (alt ? 2'b10 : 2'b11) : 2'b01) : 2'b00;
    lb_en = lb;
    sig_amp_ok = amp;
    if (lb) begin
      tx_nrzi = s;
      line_sym = s ? 2'b00 : 2'b01;
    end else begin
      tx_nrzi = ~s;
      line_sym = code;
    end
  endtask

  task automatic half_sample();
    smp_cnt++;
    if (rx_clk25) hi_cnt++;
    if (rx_grp !== prev_grp)
      chk(prev_clk && !rx_clk25, "R5 change off falling edge", {prev_clk, rx_clk25}, 2);
    prev_grp = rx_grp;
    prev_clk = rx_clk25;
  endtask

  task automatic run_seq(input int first, input int last);
    int nw;
    nw = last - first + 3;
    prev_grp = rx_grp;
    prev_clk = rx_clk25;
    hi_cnt = 0;
    smp_cnt = 0;
    for (int n = 0; n < 5 * nw; n++) begin
      logic [7:0] v;
      int w;
      w = first + n / 5;
      v = (w <= last) ? VEC[w] : 8'b0_1_0_00000;
      drive_bit(v[n % 5], v[5], v[6], v[7]);
      @(negedge clk); #1;
      half_sample();
      @(posedge clk); #1;
      half_sample();
      if (n % 5 == 2)
        chk(sig_det === (v[5] | v[6]), v[5] ? "R8 R7 loopback detect" : "R8 detect pass",
            sig_det, v[5] | v[6]);
      if (n % 5 == 0 && n >= 10) begin
        logic [7:0] e;
        e = VEC[first + n / 5 - 2];
        chk(rx_grp === e[4:0], e[5] ? "R7 R2 R3 R4 loopback group" :
            (e[7] ? "R1 R2 R3 R4 group" : "R2 R3 R4 group"), rx_grp, e[4:0]);
      end
    end
    chk(hi_cnt * 2 == smp_cnt, "R6 duty", hi_cnt, smp_cnt / 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(rx_grp === '0, "R9 reset group", rx_grp, 0);
    chk(rx_clk25 === 1'b1, "R9 reset clock", rx_clk25, 1);
    rst_n = 1;
    run_seq(0, 7);
    rst_n = 0;
    #1;
    chk(rx_grp === '0, "R9 mid-stream reset group", rx_grp, 0);
    chk(rx_clk25 === 1'b1, "R9 mid-stream reset clock", rx_clk25, 1);
    s = 0;
    neg = 1;
    @(posedge clk); #1;
    rst_n = 1;
    run_seq(8, 9);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      #200000;
    join_any
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule